// File: doc/BRIEF.md
# Programmable SPI Master Shift Engine

This block is the serial side of an SPI master. It takes parallel words from a transmit queue, shifts them out on MOSI most significant bit first, gathers the bits arriving on MISO into received words, and drives the serial clock and one of several chip-select lines. The word length is set from 4 to 32 bits, written as the length minus one. The clock idle level, the sampling phase, an internal loopback path and the chip-select polarity are all configuration inputs. The surrounding logic holds the queues and the clock divider.

Timing comes from a `tick` input that the clock divider pulses once per half SCLK period. While `run` is high and a transmit word is ready, the engine sends words back to back with no gap. When `run` goes low, the transfer ends at the next word boundary. If a word boundary arrives while `run` is still high but no transmit word is ready, the engine flags an underrun. If a received word completes while the previous one has not been taken, the engine flags an overrun. Either receive or transmit can be turned off for one-directional traffic.

Top module: `spi_shift_engine`

## Requirements
- R1: Word length is `len_m1`+1 bits, and `len_m1` values below 3 give 4-bit words. Each word produces exactly 2×length SCLK edges. MOSI carries the word's most significant bit first.
- R2: SCLK rests at the `idle_high` level out of reset, between transfers and after every complete word.
- R3: With `sample_lead`=1, MISO is sampled on the leading (first) edge of each bit and MOSI changes on the trailing edge. With `sample_lead`=0, MOSI changes on the leading edge and MISO is sampled on the trailing edge. A received word is right-aligned, and the first bit received ends up in bit length−1.
- R4: With `loop_en`=1, the received data is the transmitted data and the MISO pin has no effect.
- R5: Only the chip-select line selected by `cs_sel` ever goes active. Its active level is 1 when `cs_act_high`=1 and 0 otherwise. It is active from at least one tick before the first SCLK edge until one tick after the last edge. `cs_hold`=1 keeps it active while the engine is idle.
- R6: While `run` is high and words are available, words follow each other with no extra SCLK edges between them. One transmit word is taken per word sent. When `run` is low, the transfer ends at the current word boundary.
- R7: `err` bit 0 (underrun) sets when a word boundary comes with `run` high, transmit enabled and no transmit word ready; the transfer then stops. Both `err` bits are sticky. Writing 1 to a bit of `err_clr` clears only that bit.
- R8: `err` bit 1 (overrun) sets when a received word completes while `rx_valid` is high and `rx_ready` is low. The held word is kept and the new word is dropped.
- R9: With `rx_off`=1, no received word is offered and no overrun can occur. Shifting is unchanged.
- R10: With `tx_off`=1, no transmit word is taken, MOSI stays low, words are shifted for as long as `run` is high, and no underrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-period enable from the clock divider |
| run | input | 1 | Keep transferring while high |
| len_m1 | input | 5 | Bits per word minus one |
| idle_high | input | 1 | SCLK idle level |
| sample_lead | input | 1 | 1: sample on the leading edge; 0: sample on the trailing edge |
| loop_en | input | 1 | Route transmitted bits internally to the receiver |
| rx_off | input | 1 | Disable the receive path |
| tx_off | input | 1 | Disable the transmit path |
| cs_sel | input | 2 | Which chip-select line to drive |
| cs_hold | input | 1 | Keep the selected chip select active while idle |
| cs_act_high | input | 1 | Chip-select active level |
| tx_valid | input | 1 | A transmit word is offered |
| tx_word | input | 32 | Transmit word, right-aligned |
| tx_take | output | 1 | Transmit word consumed this cycle |
| rx_valid | output | 1 | A received word is offered |
| rx_word | output | 32 | Received word, right-aligned |
| rx_ready | input | 1 | Receiver takes the offered word |
| err_clr | input | 2 | Write-one-to-clear for `err` |
| err | output | 2 | Sticky errors: bit 1 overrun, bit 0 underrun |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
The main sweep covers every combination of clock polarity, phase and loopback over word lengths of 4, 7, 13 and 32 bits. It also includes a below-minimum length code. Each run sends three words and compares MOSI, captured on the bench's own sample edges, against the transmit words, and the received words against either the transmit words or an unrelated MISO pattern. A phase or bit-order fault therefore shows up as a shifted or reversed word, and a loopback fault shows up as the MISO pattern leaking through. Counting SCLK edges separates correct word framing from extra or missing edges. Dedicated runs stall the transmit side, stall the receiver, disable each path in turn, and hold the chip select while idle.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } eng_state_t;

    typedef struct packed {
        logic sample_lead;
        logic loop_en;
        logic rx_off;
        logic tx_off;
    } eng_mode_t;

    localparam int unsigned MIN_BITS = 4;

endpackage

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int HW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          have_word,
    input  logic [HW-1:0] nbits,
    output eng_state_t    state,
    output logic          start,
    output logic          lead_edge,
    output logic          trail_edge,
    output logic          first_edge,
    output logic          word_end,
    output logic          cont,
    output logic          underrun,
    output logic          phase
);
    logic [HW-1:0] hcnt;
    logic [HW-1:0] last_h;
    logic          hedge;

    assign last_h     = {nbits[HW-2:0], 1'b0} - HW'(1);
    assign hedge      = (state == ST_SHIFT) && tick;
    assign start      = (state == ST_IDLE) && run && have_word;
    assign lead_edge  = hedge && !hcnt[0];
    assign trail_edge = hedge && hcnt[0];
    assign first_edge = hedge && (hcnt == '0);
    assign word_end   = hedge && (hcnt == last_h);
    assign cont       = run && have_word;
    assign underrun   = word_end && run && !have_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            hcnt  <= '0;
            phase <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    hcnt  <= '0;
                    phase <= 1'b0;
                    if (start) state <= ST_LEAD;
                end
                ST_LEAD: begin
                    if (tick) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        phase <= ~phase;
                        if (hcnt == last_h) begin
                            hcnt <= '0;
                            if (!cont) state <= ST_TRAIL;
                        end else begin
                            hcnt <= hcnt + HW'(1);
                        end
                    end
                end
                default: begin
                    if (tick) state <= ST_IDLE;
                end
            endcase
        end
    end

    // R1
    hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT) |-> (hcnt <= last_h));

    // R2
    phase_even_chk: assert property (@(posedge clk) disable iff (rst)
        word_end |=> !phase);

endmodule

// File: rtl/spi_eng_tx.sv
module spi_eng_tx
    import spi_eng_pkg::*;
#(
    parameter int WMAX = 32,
    parameter int HW   = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  eng_mode_t       mode,
    input  logic [HW-1:0]   nbits,
    input  logic            load,
    input  logic            shift_now,
    input  logic [WMAX-1:0] word,
    output logic            mosi_bit
);
    logic [WMAX-1:0] shreg;
    logic [HW-1:0]   sh_amt;

    assign sh_amt   = HW'(WMAX) - nbits;
    assign mosi_bit = shreg[WMAX-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= mode.tx_off ? '0 : (word << sh_amt);
        end else if (shift_now) begin
            shreg <= {shreg[WMAX-2:0], 1'b0};
        end
    end

    // R10
    tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.tx_off && $past(mode.tx_off) && $past(load)) |-> !mosi_bit);

endmodule

// File: rtl/spi_eng_rx.sv
module spi_eng_rx
    import spi_eng_pkg::*;
#(
    parameter int WMAX = 32,
    parameter int HW   = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  eng_mode_t       mode,
    input  logic [HW-1:0]   nbits,
    input  logic            din,
    input  logic            sample,
    input  logic            word_end,
    input  logic            rx_ready,
    output logic            rx_valid,
    output logic [WMAX-1:0] rx_word,
    output logic            overrun
);
    logic [WMAX-1:0] sreg;
    logic [WMAX-1:0] sreg_nx;
    logic [WMAX-1:0] mask;
    logic [HW-1:0]   sh_amt;
    logic            slot_free;
    logic            deliver;

    assign sh_amt    = HW'(WMAX) - nbits;
    assign mask      = {WMAX{1'b1}} >> sh_amt;
    assign sreg_nx   = sample ? {sreg[WMAX-2:0], din} : sreg;
    assign slot_free = !rx_valid || rx_ready;
    assign deliver   = word_end && !mode.rx_off;
    assign overrun   = deliver && !slot_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg     <= '0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            sreg <= sreg_nx;
            if (deliver && slot_free) begin
                rx_valid <= 1'b1;
                rx_word  <= sreg_nx & mask;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_word)));

    // R9
    rx_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.rx_off && !rx_valid) |=> !rx_valid);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int WMAX = 32,
    parameter int NCS  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  logic                        run,
    input  logic [$clog2(WMAX)-1:0]     len_m1,
    input  logic                        idle_high,
    input  logic                        sample_lead,
    input  logic                        loop_en,
    input  logic                        rx_off,
    input  logic                        tx_off,
    input  logic [$clog2(NCS)-1:0]      cs_sel,
    input  logic                        cs_hold,
    input  logic                        cs_act_high,
    input  logic                        tx_valid,
    input  logic [WMAX-1:0]             tx_word,
    output logic                        tx_take,
    output logic                        rx_valid,
    output logic [WMAX-1:0]             rx_word,
    input  logic                        rx_ready,
    input  logic [1:0]                  err_clr,
    output logic [1:0]                  err,
    output logic                        sclk,
    output logic                        mosi,
    input  logic                        miso,
    output logic [NCS-1:0]              cs_o
);
    localparam int LENW = $clog2(WMAX);
    localparam int SELW = $clog2(NCS);
    localparam int HW   = $clog2(WMAX) + 2;

    eng_mode_t     mode;
    eng_state_t    state;
    logic [HW-1:0] nbits;
    logic          start, lead_edge, trail_edge, first_edge, word_end;
    logic          cont, underrun, overrun, phase;
    logic          have_word, load, sample, shift_now;
    logic          mosi_int, din, cs_on;

    assign mode = '{sample_lead: sample_lead, loop_en: loop_en,
                    rx_off: rx_off, tx_off: tx_off};

    assign nbits = (len_m1 < LENW'(MIN_BITS - 1)) ? HW'(MIN_BITS)
                                                  : HW'(len_m1) + HW'(1);

    assign have_word = tx_off || tx_valid;
    assign load      = start || (word_end && cont);
    assign tx_take   = !tx_off && load;
    assign sample    = sample_lead ? lead_edge : trail_edge;
    assign shift_now = sample_lead ? (trail_edge && !word_end)
                                   : (lead_edge && !first_edge);
    assign din       = loop_en ? mosi_int : miso;
    assign mosi      = mosi_int;
    assign sclk      = idle_high ^ phase;
    assign cs_on     = (state != ST_IDLE) || cs_hold;

    spi_eng_seq #(.HW(HW)) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .have_word(have_word),
        .nbits(nbits), .state(state), .start(start), .lead_edge(lead_edge),
        .trail_edge(trail_edge), .first_edge(first_edge), .word_end(word_end),
        .cont(cont), .underrun(underrun), .phase(phase)
    );

    spi_eng_tx #(.WMAX(WMAX), .HW(HW)) u_tx (
        .clk(clk), .rst(rst), .mode(mode), .nbits(nbits), .load(load),
        .shift_now(shift_now), .word(tx_word), .mosi_bit(mosi_int)
    );

    spi_eng_rx #(.WMAX(WMAX), .HW(HW)) u_rx (
        .clk(clk), .rst(rst), .mode(mode), .nbits(nbits), .din(din),
        .sample(sample), .word_end(word_end), .rx_ready(rx_ready),
        .rx_valid(rx_valid), .rx_word(rx_word), .overrun(overrun)
    );

    generate
        for (genvar i = 0; i < NCS; i++) begin : g_cs
            assign cs_o[i] = (cs_on && (cs_sel == SELW'(i))) ? cs_act_high
                                                             : ~cs_act_high;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 2'b00;
        end else begin
            err <= (err & ~err_clr) | {overrun, underrun};
        end
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(err[0]) && !$past(err_clr[0])) |-> err[0]);

    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_act_high ? cs_o : ~cs_o));

    // R5
    cs_cover_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk != idle_high) |-> (cs_o[cs_sel] == cs_act_high));

    // R10
    no_take_chk: assert property (@(posedge clk) disable iff (rst)
        tx_off |-> !tx_take);

endmodule

// File: tb/test_spi_shift_engine.sv
`timescale 1ns/1ps
module test_spi_shift_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        run = 1'b0;
    logic [4:0]  len_m1 = 5'd7;
    logic        idle_high = 1'b0;
    logic        sample_lead = 1'b1;
    logic        loop_en = 1'b0;
    logic        rx_off = 1'b0;
    logic        tx_off = 1'b0;
    logic [1:0]  cs_sel = 2'd0;
    logic        cs_hold = 1'b0;
    logic        cs_act_high = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_word = '0;
    logic        tx_take;
    logic        rx_valid;
    logic [31:0] rx_word;
    logic        rx_ready = 1'b1;
    logic [1:0]  err_clr = 2'b00;
    logic [1:0]  err;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_o;

    spi_shift_engine i_spi_shift_engine (
        .clk(clk), .rst(rst), .tick(tick), .run(run), .len_m1(len_m1),
        .idle_high(idle_high), .sample_lead(sample_lead), .loop_en(loop_en),
        .rx_off(rx_off), .tx_off(tx_off), .cs_sel(cs_sel), .cs_hold(cs_hold),
        .cs_act_high(cs_act_high), .tx_valid(tx_valid), .tx_word(tx_word),
        .tx_take(tx_take), .rx_valid(rx_valid), .rx_word(rx_word),
        .rx_ready(rx_ready), .err_clr(err_clr), .err(err), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_o(cs_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        #1;
        tick = ~tick;
    end

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int seed = 0;

    int c_n = 8, c_cpol = 0, c_cpha = 0, c_sel = 0;
    logic c_act = 1'b0;
    logic mon_on = 1'b0;
    int m_edges, m_takes, m_nr, m_nw, m_k, m_ones, m_csbad;
    logic [31:0] m_cap;
    logic [31:0] m_rx [8];
    logic [31:0] m_mosi [8];
    logic prev_sclk = 1'b0;
    logic prev_mosi = 1'b0;

    function automatic logic [31:0] nmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    function automatic logic [31:0] wgen(input int j);
        return (32'h9E37_79B1 * (j + 1 + seed)) ^ (32'h0101_0101 * seed);
    endfunction

    function automatic logic [31:0] slv(input int j);
        return ~wgen(j) ^ 32'h3C3C_00FF;
    endfunction

    function automatic logic slv_bit(input int j, input int k);
        logic [31:0] s;
        s = slv(j);
        return s[c_n - 1 - k];
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (tx_take) m_takes++;
            if (rx_valid && rx_ready) begin
                if (m_nr < 8) m_rx[m_nr] = rx_word;
                m_nr++;
            end
            if (sclk != prev_sclk) begin
                m_edges++;
                if (cs_o[c_sel] != c_act) m_csbad++;
                if (((prev_sclk == c_cpol[0]) ? 1 : 0) == ((c_cpha == 0) ? 1 : 0)) begin
                    m_cap = {m_cap[30:0], prev_mosi};
                    m_ones += int'(prev_mosi);
                    m_k++;
                    if (m_k == c_n) begin
                        if (m_nw < 8) m_mosi[m_nw] = m_cap & nmask(c_n);
                        m_nw++;
                        m_k = 0;
                        m_cap = '0;
                    end
                end
            end
            if (sclk != c_cpol[0] && cs_o[c_sel] != c_act) m_csbad++;
            for (int i = 0; i < 4; i++)
                if (i != c_sel && cs_o[i] != !c_act) m_csbad++;
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
        miso = slv_bit(m_nw, m_k);
    end

    task automatic setup(input int lm1, input int cpol, input int cpha,
                         input int lp, input int sel, input logic act);
        @(posedge clk); #1;
        len_m1 = 5'(lm1);
        idle_high = cpol[0];
        sample_lead = (cpha == 0);
        loop_en = lp[0];
        cs_sel = 2'(sel);
        cs_act_high = act;
        c_n = (lm1 < 3) ? 4 : lm1 + 1;
        c_cpol = cpol; c_cpha = cpha; c_sel = sel; c_act = act;
        m_edges = 0; m_takes = 0; m_nr = 0; m_nw = 0; m_k = 0;
        m_ones = 0; m_csbad = 0; m_cap = '0;
        @(posedge clk); #1;
        mon_on = 1'b1;
    endtask

    task automatic xfer(input int nwords, input logic keep_run);
        int idx = 0;
        logic t;
        if (tx_off) begin
            tx_valid = 1'b0;
            run = 1'b1;
            while (m_nr < nwords) @(negedge clk);
            @(posedge clk); #1;
            run = 1'b0;
        end else begin
            tx_word = wgen(0);
            tx_valid = 1'b1;
            run = 1'b1;
            while (idx < nwords) begin
                @(negedge clk);
                t = tx_take;
                @(posedge clk); #1;
                if (t) begin
                    idx++;
                    if (idx == nwords) begin
                        tx_valid = 1'b0;
                        if (!keep_run) run = 1'b0;
                    end else begin
                        tx_word = wgen(idx);
                    end
                end
            end
        end
        @(negedge clk);
        while (cs_o[c_sel] == c_act) @(negedge clk);
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
    endtask

    initial begin
        logic [31:0] mk;
        int lens [5] = '{1, 3, 6, 12, 31};
        int ridx = 0;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R2 reset sclk idle", {31'b0, sclk}, 32'h0);
        chk(cs_o == 4'hF, "R5 reset cs inactive", {28'b0, cs_o}, 32'hF);
        chk(err == 2'b00 && !rx_valid && !tx_take, "R7 reset err/rx/take",
            {29'b0, err, rx_valid}, 32'h0);

        for (int li = 0; li < 5; li++)
            for (int cfg = 0; cfg < 8; cfg++) begin
                seed = ridx * 7 + 3;
                setup(lens[li], cfg & 1, (cfg >> 1) & 1, (cfg >> 2) & 1,
                      ridx % 4, ridx[2]);
                xfer(3, 1'b0);
                mk = nmask(c_n);
                for (int j = 0; j < 3; j++) begin
                    chk(m_mosi[j] == (wgen(j) & mk), "R1 R3 mosi word msb first",
                        m_mosi[j], wgen(j) & mk);
                    if (loop_en)
                        chk(m_rx[j] == (wgen(j) & mk), "R4 loopback rx word",
                            m_rx[j], wgen(j) & mk);
                    else
                        chk(m_rx[j] == (slv(j) & mk), "R3 miso rx word",
                            m_rx[j], slv(j) & mk);
                end
                chk(m_edges == 6 * c_n, "R1 R6 edge count", m_edges, 6 * c_n);
                chk(m_nr == 3 && m_takes == 3, "R6 words out/in",
                    m_nr * 16 + m_takes, 32'h33);
                chk(m_csbad == 0, "R5 chip select framing", m_csbad, 0);
                chk(sclk == idle_high, "R2 sclk back to idle", {31'b0, sclk},
                    {31'b0, idle_high});
                chk(err == 2'b00, "R7 no error in normal run", {30'b0, err}, 0);
                ridx++;
            end

        // R8 overrun: receiver stalled
        seed = 91;
        rx_ready = 1'b0;
        setup(7, 0, 0, 1, 1, 1'b0);
        xfer(3, 1'b0);
        chk(err == 2'b10, "R8 overrun flag", {30'b0, err}, 32'h2);
        chk(rx_valid && rx_word == (wgen(0) & 32'hFF), "R8 first word held",
            rx_word, wgen(0) & 32'hFF);
        @(posedge clk); #1 rx_ready = 1'b1;
        @(posedge clk); #1 err_clr = 2'b10;
        @(posedge clk); #1 err_clr = 2'b00;
        @(negedge clk);
        chk(!rx_valid, "R8 held word drained", {31'b0, rx_valid}, 0);
        chk(err == 2'b00, "R7 overrun cleared", {30'b0, err}, 0);

        // R7 underrun: run stays high with no word
        seed = 17;
        setup(12, 1, 1, 1, 3, 1'b1);
        xfer(1, 1'b1);
        chk(err == 2'b01, "R7 underrun flag", {30'b0, err}, 32'h1);
        chk(m_edges == 2 * c_n && m_nr == 1, "R7 stop at boundary",
            m_edges, 2 * c_n);
        @(posedge clk); #1 err_clr = 2'b10;
        @(posedge clk); #1 err_clr = 2'b00;
        @(negedge clk);
        chk(err == 2'b01, "R7 other bit clear leaves underrun", {30'b0, err}, 32'h1);
        @(posedge clk); #1 err_clr = 2'b01;
        @(posedge clk); #1 err_clr = 2'b00; run = 1'b0;
        @(negedge clk);
        chk(err == 2'b00, "R7 underrun cleared", {30'b0, err}, 0);

        // R9 receive disabled
        seed = 29;
        rx_off = 1'b1;
        setup(15, 0, 1, 1, 2, 1'b0);
        xfer(2, 1'b0);
        chk(m_nr == 0 && !rx_valid, "R9 no rx words", m_nr, 0);
        chk(m_edges == 4 * c_n && err == 2'b00, "R9 shifting unchanged",
            m_edges, 4 * c_n);
        rx_off = 1'b0;

        // R10 transmit disabled
        seed = 33;
        tx_off = 1'b1;
        setup(9, 1, 0, 1, 0, 1'b0);
        xfer(2, 1'b0);
        chk(m_takes == 0 && m_ones == 0, "R10 no take, mosi low",
            m_takes + m_ones, 0);
        chk(m_nr >= 2 && m_rx[0] == 0 && m_rx[1] == 0, "R10 zero words looped",
            m_rx[0] | m_rx[1], 0);
        chk(err == 2'b00 && m_edges == 2 * c_n * m_nr, "R10 no underrun, whole words",
            m_edges, 2 * c_n * m_nr);
        tx_off = 1'b0;

        // R5 hold while idle
        @(posedge clk); #1 cs_hold = 1'b1; cs_sel = 2'd2; cs_act_high = 1'b0;
        @(negedge clk);
        chk(cs_o == 4'b1011, "R5 hold active low", {28'b0, cs_o}, 32'hB);
        @(posedge clk); #1 cs_act_high = 1'b1;
        @(negedge clk);
        chk(cs_o == 4'b0100, "R5 hold active high", {28'b0, cs_o}, 32'h4);
        @(posedge clk); #1 cs_hold = 1'b0;
        @(negedge clk);
        chk(cs_o == 4'b0000, "R5 release hold", {28'b0, cs_o}, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule